// File: doc/BRIEF.md
# Block-Transfer Register List Sequencer

This block steps a processor's load-multiple or store-multiple operation through its register list. A one-cycle start pulse hands it a 16-bit mask of registers, a base address and two mode bits: one chooses whether the address moves before or after each transfer (pre/post), the other whether addresses rise or fall (up/down). The block then presents one memory transfer per set bit in the mask on a valid/ready port. Each transfer carries a 4-bit register number and a 32-bit word address.

The next register is found by a two-level priority search. Each 4-bit group of the mask is first reduced to a non-empty flag. The lowest or highest non-empty group is picked according to direction. The lowest or highest set bit inside that group then supplies the low index bits. Each accepted transfer clears its bit from an internal copy of the mask. When the copy is empty, the block raises a one-cycle done pulse together with the address that the base register should be written back with.

Top module: `lst_block_seq`

## Requirements
- R1: After reset, `xfer_valid_o`, `done_o` and `busy_o` are low.
- R2: The block makes exactly one transfer per set bit of the list. With up=1 the register numbers rise from 0 to 15. With up=0 they fall from 15 to 0. Bit 15 is treated like every other bit.
- R3: The mode code {pre, up} selects the first transfer address. 01 (increment-after) gives base. 11 (increment-before) gives base+4. 00 (decrement-after) gives base. 10 (decrement-before) gives base-4.
- R4: Each accepted transfer moves the address of the next transfer by +4 when up=1 and by -4 when up=0, modulo 2^32.
- R5: The writeback address is the last transfer address plus 4 for increment-after, plus 0 for increment-before, minus 4 for decrement-after and minus 0 for decrement-before. This equals base+4N when up=1 and base-4N when up=0, where N is the number of set bits.
- R6: While `xfer_valid_o` is high and `xfer_ready_i` is low, the transfer is held: valid stays high, and register number and address are unchanged in the next cycle.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last accepted transfer. `xfer_valid_o` is low in that cycle, and `wb_addr_o` holds the writeback address while `done_o` is high.
- R8: An all-zero list produces no transfer. `done_o` rises in the cycle after start, with `wb_addr_o` equal to base.
- R9: `busy_o` is high from the cycle after an accepted start through the done cycle. A start while `busy_o` is high is ignored, including one in the done cycle, and `busy_o` is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| list_i | input | 16 | Register list mask, bit n selects register n |
| base_i | input | 32 | Base address |
| pre_i | input | 1 | 1: address moves before the transfer, 0: after |
| up_i | input | 1 | 1: ascending walk, 0: descending walk |
| xfer_valid_o | output | 1 | A transfer is presented |
| xfer_ready_i | input | 1 | Memory port accepts the transfer |
| xfer_reg_o | output | 4 | Register number of the transfer |
| xfer_addr_o | output | 32 | Address of the transfer |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_addr_o | output | 32 | Writeback address, valid with done_o |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The hardest situations to reach are a start request that lands mid-sequence while the memory port is stalling, and one that lands in the done cycle itself. In both, a wrongly accepted start would only show up through a changed register order or address later in the run. The bench therefore drives a different mask and base with a start pulse on a stalled transfer and again on the done cycle. It then keeps checking every following transfer, and checks that the block goes idle afterwards. This stimulus runs inside a sweep over all four modes. The sweep uses empty, full, one-hot and one-cold masks plus pseudo-random masks, under three ready patterns, so groups that are empty on either side of the chosen group are covered in both walk directions.

// File: rtl/lst_pkg.sv
package lst_pkg;

    parameter int LIST_W  = 16;
    parameter int GROUP_W = 4;
    parameter int ADDR_W  = 32;
    parameter int STEP    = 4;

    localparam int N_GROUPS = LIST_W / GROUP_W;
    localparam int IDX_W    = $clog2(LIST_W);
    localparam int BIT_W    = $clog2(GROUP_W);
    localparam int GRP_W    = $clog2(N_GROUPS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pre;
        logic up;
    } walk_mode_t;

    typedef struct packed {
        logic [IDX_W-1:0]  reg_idx;
        logic [ADDR_W-1:0] addr;
    } xfer_beat_t;

    // Signed step per accepted transfer, in address width.
    function automatic logic [ADDR_W-1:0] addr_step(walk_mode_t m);
        return m.up ? ADDR_W'(STEP) : (ADDR_W'(0) - ADDR_W'(STEP));
    endfunction

    // Offset from base to the first transfer address.
    function automatic logic [ADDR_W-1:0] first_offset(walk_mode_t m);
        return m.pre ? addr_step(m) : ADDR_W'(0);
    endfunction

    // Offset from the last transfer address to the writeback address.
    function automatic logic [ADDR_W-1:0] final_offset(walk_mode_t m);
        return m.pre ? ADDR_W'(0) : addr_step(m);
    endfunction

endpackage

// File: rtl/lst_prio_pick.sv
module lst_prio_pick #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    input  logic          up_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // up_i=1: lowest set bit wins; up_i=0: highest set bit wins.
    always_comb begin
        idx_o = '0;
        if (up_i) begin
            for (int i = W - 1; i >= 0; i--) begin
                if (vec_i[i]) idx_o = IW'(i);
            end
        end else begin
            for (int i = 0; i < W; i++) begin
                if (vec_i[i]) idx_o = IW'(i);
            end
        end
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/lst_next_pick.sv
module lst_next_pick
    import lst_pkg::*;
(
    input  logic [LIST_W-1:0] mask_i,
    input  logic              up_i,
    output logic [IDX_W-1:0]  reg_idx_o,
    output logic              any_o
);

    logic [N_GROUPS-1:0] grp_flag;
    logic [BIT_W-1:0]    bit_idx [N_GROUPS];
    logic [GRP_W-1:0]    grp_sel;

    // First level: one picker per group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
        lst_prio_pick #(.W(GROUP_W), .IW(BIT_W)) u_bits (
            .vec_i (mask_i[g*GROUP_W +: GROUP_W]),
            .up_i  (up_i),
            .idx_o (bit_idx[g]),
            .any_o (grp_flag[g])
        );
    end

    // Second level: pick among non-empty groups.
    lst_prio_pick #(.W(N_GROUPS), .IW(GRP_W)) u_groups (
        .vec_i (grp_flag),
        .up_i  (up_i),
        .idx_o (grp_sel),
        .any_o (any_o)
    );

    assign reg_idx_o = {grp_sel, bit_idx[grp_sel]};

endmodule

// File: rtl/lst_addr_walk.sv
module lst_addr_walk
    import lst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  walk_mode_t        mode_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] wb_next_o
);

    walk_mode_t        mode_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            mode_q <= mode_i;
            addr_q <= base_i + first_offset(mode_i);
        end else if (adv_i) begin
            addr_q <= addr_q + addr_step(mode_q);
        end
    end

    assign addr_o    = addr_q;
    assign wb_next_o = addr_q + final_offset(mode_q);

endmodule

// File: rtl/lst_block_seq.sv
module lst_block_seq
    import lst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LIST_W-1:0] list_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              pre_i,
    input  logic              up_i,
    output logic              xfer_valid_o,
    input  logic              xfer_ready_i,
    output logic [IDX_W-1:0]  xfer_reg_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic              busy_o
);

    seq_state_e        state_q;
    logic [LIST_W-1:0] mask_q;
    logic              up_q;
    logic [ADDR_W-1:0] wb_q;

    logic              start_ok;
    logic              fire;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic [LIST_W-1:0] mask_next;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wb_next;
    walk_mode_t        req_mode;
    xfer_beat_t        beat;

    assign req_mode = '{pre: pre_i, up: up_i};
    assign start_ok = start_i && (state_q == ST_IDLE);
    assign fire     = xfer_valid_o && xfer_ready_i;

    lst_next_pick u_pick (
        .mask_i    (mask_q),
        .up_i      (up_q),
        .reg_idx_o (pick_idx),
        .any_o     (pick_any)
    );

    lst_addr_walk u_walk (
        .clk       (clk),
        .rst       (rst),
        .load_i    (start_ok),
        .base_i    (base_i),
        .mode_i    (req_mode),
        .adv_i     (fire),
        .addr_o    (cur_addr),
        .wb_next_o (wb_next)
    );

    assign mask_next = mask_q & ~(LIST_W'(1) << pick_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            up_q    <= 1'b0;
            wb_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mask_q <= list_i;
                        up_q   <= up_i;
                        if (list_i == '0) begin
                            state_q <= ST_DONE;
                            wb_q    <= base_i;
                        end else begin
                            state_q <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (fire) begin
                        mask_q <= mask_next;
                        if (mask_next == '0) begin
                            state_q <= ST_DONE;
                            wb_q    <= wb_next;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign beat.reg_idx = pick_idx;
    assign beat.addr    = cur_addr;

    assign xfer_valid_o = (state_q == ST_XFER) && pick_any;
    assign xfer_reg_o   = beat.reg_idx;
    assign xfer_addr_o  = beat.addr;
    assign done_o       = (state_q == ST_DONE);
    assign busy_o       = (state_q != ST_IDLE);
    assign wb_addr_o    = wb_q;

endmodule

// File: rtl/lst_block_seq_chk.sv
module lst_block_seq_chk
    import lst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [LIST_W-1:0] list_i,
    input logic [ADDR_W-1:0] base_i,
    input logic              pre_i,
    input logic              up_i,
    input logic              xfer_valid_o,
    input logic              xfer_ready_i,
    input logic [IDX_W-1:0]  xfer_reg_o,
    input logic [ADDR_W-1:0] xfer_addr_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] wb_addr_o,
    input logic              busy_o
);

    logic              dir_c;
    logic [ADDR_W-1:0] step_c;

    always_ff @(posedge clk) begin
        if (rst) dir_c <= 1'b0;
        else if (start_i && !busy_o) dir_c <= up_i;
    end

    always_comb step_c = dir_c ? ADDR_W'(STEP) : (ADDR_W'(0) - ADDR_W'(STEP));

    p_walk_order_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o ||
            (dir_c ? (xfer_reg_o > $past(xfer_reg_o)) : (xfer_reg_o < $past(xfer_reg_o)))));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o ||
            (xfer_addr_o == ADDR_W'($past(xfer_addr_o) + step_c))));

    p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !xfer_ready_i) |=>
            (xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !xfer_valid_o);

    p_empty_list_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (list_i == '0)) |=>
            (done_o && !xfer_valid_o && (wb_addr_o == $past(base_i))));

    p_start_in_done_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

endmodule

bind lst_block_seq lst_block_seq_chk u_chk (.*);

// File: tb/test_lst_block_seq.sv
`timescale 1ns/1ps
module test_lst_block_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] list_i = '0;
    logic [31:0] base_i = '0;
    logic        pre_i = 1'b0;
    logic        up_i = 1'b0;
    logic        xfer_ready_i = 1'b0;
    logic        xfer_valid_o;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o;
    logic        done_o;
    logic [31:0] wb_addr_o;
    logic        busy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lst_block_seq i_lst_block_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .list_i       (list_i),
        .base_i       (base_i),
        .pre_i        (pre_i),
        .up_i         (up_i),
        .xfer_valid_o (xfer_valid_o),
        .xfer_ready_i (xfer_ready_i),
        .xfer_reg_o   (xfer_reg_o),
        .xfer_addr_o  (xfer_addr_o),
        .done_o       (done_o),
        .wb_addr_o    (wb_addr_o),
        .busy_o       (busy_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int next_idx(input logic [15:0] m, input bit up);
        if (up) begin
            for (int i = 0; i < 16; i++) if (m[i]) return i;
        end else begin
            for (int i = 15; i >= 0; i--) if (m[i]) return i;
        end
        return -1;
    endfunction

    task automatic run_seq(input logic [15:0] mask, input logic [31:0] base,
                           input bit pre, input bit up, input int stall_kind, input bit poke);
        logic [15:0] rem = mask;
        logic [31:0] exp_addr;
        logic [31:0] exp_wb;
        int n = $countones(mask);
        int beats = 0;
        int cyc = 0;
        bit seen_done = 0;
        bit rdy;
        exp_addr = base + (pre ? (up ? 32'd4 : 32'hFFFF_FFFC) : 32'd0);
        exp_wb   = up ? base + 32'(4 * n) : base - 32'(4 * n);
        @(negedge clk);
        start_i = 1'b1; list_i = mask; base_i = base; pre_i = pre; up_i = up;
        @(negedge clk);
        start_i = 1'b0; list_i = ~mask; base_i = ~base; pre_i = ~pre; up_i = ~up;
        while (!seen_done && cyc < 80) begin
            if (done_o) begin
                seen_done = 1;
                if (mask == 16'h0) check("R8", "done one cycle after empty start", 32'(cyc), 32'd0);
                check(mask == 16'h0 ? "R8" : "R5", "writeback address", wb_addr_o, exp_wb);
                check("R2", "transfer count", 32'(beats), 32'(n));
                check("R7", "valid low in done cycle", 32'(xfer_valid_o), 32'd0);
                check("R9", "busy in done cycle", 32'(busy_o), 32'd1);
                if (poke) begin
                    start_i = 1'b1; list_i = 16'h00F0; base_i = 32'h55AA_0000;
                end
                @(negedge clk);
                start_i = 1'b0;
                check("R7", "done lasts one cycle", 32'(done_o), 32'd0);
                check("R9", "idle after done, start ignored", 32'(busy_o), 32'd0);
                check("R9", "no transfer after done", 32'(xfer_valid_o), 32'd0);
            end else if (xfer_valid_o) begin
                check("R2", "register number", 32'(xfer_reg_o), 32'(next_idx(rem, up)));
                check(beats == 0 ? "R3" : "R4", "transfer address", xfer_addr_o, exp_addr);
                case (stall_kind)
                    0:       rdy = 1'b1;
                    1:       rdy = (cyc % 3) != 1;
                    default: rdy = (cyc % 2) == 0;
                endcase
                if (poke && cyc == 1) begin
                    start_i = 1'b1; list_i = 16'h8001; base_i = 32'hDEAD_0000;
                end
                xfer_ready_i = rdy;
                @(negedge clk);
                xfer_ready_i = 1'b0;
                start_i = 1'b0;
                if (rdy) begin
                    int k = next_idx(rem, up);
                    if (k >= 0) rem[k] = 1'b0;
                    beats++;
                    exp_addr = exp_addr + (up ? 32'd4 : 32'hFFFF_FFFC);
                end else if (!xfer_valid_o) begin
                    check("R6", "valid held under stall", 32'(xfer_valid_o), 32'd1);
                end
            end else begin
                check("R2", "neither valid nor done while running", 32'(busy_o), 32'd2);
                @(negedge clk);
            end
            cyc++;
        end
        if (!seen_done) check("R7", "done never seen", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [15:0] masks [74];
        int run = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "valid after reset", 32'(xfer_valid_o), 32'd0);
        check("R1", "done after reset", 32'(done_o), 32'd0);
        check("R1", "busy after reset", 32'(busy_o), 32'd0);
        masks[0] = 16'h0000;
        masks[1] = 16'hFFFF;
        for (int i = 0; i < 16; i++) begin
            masks[2 + i]  = 16'(1 << i);
            masks[18 + i] = ~16'(1 << i);
        end
        for (int i = 34; i < 74; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            masks[i] = lfsr;
        end
        for (int m = 0; m < 4; m++) begin
            for (int j = 0; j < 74; j++) begin
                logic [31:0] base;
                base = (j % 7 == 0) ? 32'h0000_0004 : {lfsr, 16'h0} + 32'(j * 12);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                run_seq(masks[j], base, m[1], m[0], run % 3, (run % 5) == 0);
                run++;
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule